// File: doc/BRIEF.md
# Low-power sleep mode controller

This block tracks the power state of a processor core. While the core runs, a sleep request from the instruction pipeline moves it into one of three low-power states. The depth of that state comes from two standby-control bits, read by priority: the standby bit wins over the deep-sleep bit, and with neither set the core takes a plain sleep. Each state stops a different set of functions. The core clock stops in all three. The DMA engine halts in deep sleep and in standby. The timer, serial port and performance counters halt only in standby.

A pending interrupt in any low-power state brings the core back to running on the next clock edge. A synchronous reset forces running from any state. A sleep request that arrives outside running has no effect. The state is held in a register, and every enable output is decoded from that register, so all outputs change on the same edge as the state.

States: RUN (code 0), LIGHT sleep (code 1), DEEP sleep (code 2), STBY standby (code 3). Transitions:
- RUN→STBY on a sleep request with the standby bit set.
- RUN→DEEP on a sleep request with the standby bit clear and the deep bit set.
- RUN→LIGHT on a sleep request with both bits clear.
- LIGHT, DEEP or STBY→RUN on a pending interrupt.
- Any state→RUN on reset.
- With no trigger, every state holds.

Top module: `slp_power_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state is RUN (pwr_state 0), whatever the current state and the other inputs are. core_run is 1, and clk_stop, periph_halt and dma_halt are 0.
- R2: In RUN with sleep_req low, the state stays RUN.
- R3: In RUN with sleep_req high and stby_sel high, the next state is STBY (3), whatever deep_sel is.
- R4: In RUN with sleep_req high, stby_sel low and deep_sel high, the next state is DEEP (2).
- R5: In RUN with sleep_req high and both select bits low, the next state is LIGHT (1).
- R6: In LIGHT, DEEP or STBY with irq_pending high, the next state is RUN, even if sleep_req is high in the same cycle.
- R7: In LIGHT, DEEP or STBY with irq_pending low, the state holds. sleep_req, stby_sel and deep_sel have no effect.
- R8: core_run is 1 only in RUN. clk_stop is 1 in each of LIGHT, DEEP and STBY.
- R9: periph_halt (bit 0 timer, bit 1 serial port, bit 2 performance counters) is all ones in STBY and all zeros in every other state.
- R10: dma_halt is 1 in DEEP and in STBY, and 0 in RUN and LIGHT.
- R11: In RUN, a sleep request and a pending interrupt in the same cycle still take the sleep transition. The low-power state then lasts one cycle if the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction executed |
| stby_sel | input | 1 | Standby select bit (highest priority) |
| deep_sel | input | 1 | Deep-sleep select bit |
| irq_pending | input | 1 | An interrupt is pending |
| pwr_state | output | 2 | Registered power state code |
| core_run | output | 1 | Core execute enable |
| clk_stop | output | 1 | Core clock-stop enable |
| periph_halt | output | 3 | Halt enables: timer, serial port, performance counters |
| dma_halt | output | 1 | DMA halt enable |

## Verification
Two events can share a cycle: a sleep request and a pending interrupt. Their outcome depends on the state they meet. In RUN the sleep request wins and the interrupt wakes the core one cycle later. In a low-power state the interrupt wins and the request is discarded. Directed steps drive both inputs high together in RUN and in each low-power state. Random stimulus raises irq_pending and sleep_req often enough to produce many more such cycles. A bench model predicts each state, and the registered state and all enables are compared with it every cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_LIGHT = 2'd1,
        PS_DEEP  = 2'd2,
        PS_STBY  = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/slp_depth_sel.sv
module slp_depth_sel
    import slp_pkg::*;
(
    input  logic       stby_sel,
    input  logic       deep_sel,
    output pwr_state_t target
);
    // Priority pick: standby over deep sleep over light sleep
    always_comb begin
        if (stby_sel)      target = PS_STBY;
        else if (deep_sel) target = PS_DEEP;
        else               target = PS_LIGHT;
    end
endmodule

// File: rtl/slp_state_fsm.sv
module slp_state_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       irq_pending,
    input  logic       stby_sel,
    input  logic       deep_sel,
    input  pwr_state_t target,
    output pwr_state_t state_q
);
    pwr_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:   if (sleep_req)   state_d = target;
            PS_LIGHT: if (irq_pending) state_d = PS_RUN;
            PS_DEEP:  if (irq_pending) state_d = PS_RUN;
            PS_STBY:  if (irq_pending) state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    AST_STAY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && !sleep_req) |=> (state_q == PS_RUN)); // R2
    AST_STBY_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && sleep_req && stby_sel) |=> (state_q == PS_STBY)); // R3
    AST_DEEP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && sleep_req && !stby_sel && deep_sel) |=> (state_q == PS_DEEP)); // R4
    AST_LIGHT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && sleep_req && !stby_sel && !deep_sel) |=> (state_q == PS_LIGHT)); // R5
    AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && irq_pending) |=> (state_q == PS_RUN)); // R6
    AST_HOLD_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && !irq_pending) |=> $stable(state_q)); // R7
endmodule

// File: rtl/slp_out_dec.sv
module slp_out_dec
    import slp_pkg::*;
#(
    parameter int NUM_PERIPH = 3
)(
    input  pwr_state_t            state_q,
    output logic                  core_run,
    output logic                  clk_stop,
    output logic [NUM_PERIPH-1:0] periph_halt,
    output logic                  dma_halt
);
    logic halt_all;

    always_comb begin
        core_run = 1'b0;
        clk_stop = 1'b1;
        halt_all = 1'b0;
        dma_halt = 1'b0;
        unique case (state_q)
            PS_RUN: begin
                core_run = 1'b1;
                clk_stop = 1'b0;
            end
            PS_LIGHT: begin
            end
            PS_DEEP: begin
                dma_halt = 1'b1;
            end
            PS_STBY: begin
                dma_halt = 1'b1;
                halt_all = 1'b1;
            end
        endcase
    end

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
        assign periph_halt[g] = halt_all;
    end
endmodule

// File: rtl/slp_power_ctrl.sv
module slp_power_ctrl
    import slp_pkg::*;
#(
    parameter int NUM_PERIPH = 3
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_req,
    input  logic                  stby_sel,
    input  logic                  deep_sel,
    input  logic                  irq_pending,
    output logic [1:0]            pwr_state,
    output logic                  core_run,
    output logic                  clk_stop,
    output logic [NUM_PERIPH-1:0] periph_halt,
    output logic                  dma_halt
);
    pwr_state_t target;
    pwr_state_t state_q;

    slp_depth_sel u_sel (
        .stby_sel (stby_sel),
        .deep_sel (deep_sel),
        .target   (target)
    );

    slp_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .irq_pending (irq_pending),
        .stby_sel    (stby_sel),
        .deep_sel    (deep_sel),
        .target      (target),
        .state_q     (state_q)
    );

    slp_out_dec #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
        .state_q     (state_q),
        .core_run    (core_run),
        .clk_stop    (clk_stop),
        .periph_halt (periph_halt),
        .dma_halt    (dma_halt)
    );

    assign pwr_state = state_q;

    AST_RESET_RUN: assert property (@(posedge clk)
        !rst_n |=> (core_run && !clk_stop && !dma_halt)); // R1
    AST_CLK_VS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run != clk_stop)); // R8
    AST_PERIPH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_halt) |-> (dma_halt && clk_stop)); // R9
    AST_DMA_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_halt |-> !core_run); // R10
    AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && sleep_req && irq_pending) |=> clk_stop); // R11
endmodule

// File: tb/tb_slp_power_ctrl.sv
`timescale 1ns/1ps
module tb_slp_power_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, stby_sel = 1'b0, deep_sel = 1'b0, irq_pending = 1'b0;
    logic [1:0] pwr_state;
    logic       core_run, clk_stop, dma_halt;
    logic [2:0] periph_halt;

    int checks = 0;
    int failures = 0;
    logic [1:0] exp_st = 2'd0;

    always #2 clk = ~clk;

    slp_power_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
        .deep_sel(deep_sel), .irq_pending(irq_pending), .pwr_state(pwr_state),
        .core_run(core_run), .clk_stop(clk_stop), .periph_halt(periph_halt),
        .dma_halt(dma_halt)
    );

    function automatic logic [1:0] model_next(logic [1:0] cur, logic r, logic s,
                                              logic st, logic dp, logic irq);
        if (!r) return 2'd0;
        if (cur == 2'd0) begin
            if (!s) return 2'd0;
            if (st) return 2'd3;
            if (dp) return 2'd2;
            return 2'd1;
        end
        return irq ? 2'd0 : cur;
    endfunction

    function automatic string model_tag(logic [1:0] cur, logic r, logic s,
                                        logic st, logic dp, logic irq);
        if (!r) return "R1";
        if (cur == 2'd0) begin
            if (!s) return "R2";
            if (irq) return "R11";
            if (st) return "R3";
            if (dp) return "R4";
            return "R5";
        end
        return irq ? "R6" : "R7";
    endfunction

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check(tag, "pwr_state", {2'b0, pwr_state}, {2'b0, exp_st});
        check((tag == "R1") ? "R1" : "R8", "core_run", {3'b0, core_run}, {3'b0, exp_st == 2'd0});
        check((tag == "R1") ? "R1" : "R8", "clk_stop", {3'b0, clk_stop}, {3'b0, exp_st != 2'd0});
        check((tag == "R1") ? "R1" : "R9", "periph_halt", {1'b0, periph_halt},
              (exp_st == 2'd3) ? 4'h7 : 4'h0);
        check((tag == "R1") ? "R1" : "R10", "dma_halt", {3'b0, dma_halt}, {3'b0, exp_st >= 2'd2});
    endtask

    // Called at a falling edge: apply inputs, advance model, check at next falling edge
    task automatic step(logic r, logic s, logic st, logic dp, logic irq);
        string tag;
        rst_n = r; sleep_req = s; stby_sel = st; deep_sel = dp; irq_pending = irq;
        tag = model_tag(exp_st, r, s, st, dp, irq);
        exp_st = model_next(exp_st, r, s, st, dp, irq);
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);      // R1 reset state
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);      // R2 stay running
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);      // R3 standby wins over deep
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);      // R7 request ignored in standby
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);      // R6 wake despite sleep_req
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);      // R4 deep sleep
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);      // R7 hold deep
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);      // R6 wake
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);      // R5 light sleep
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);      // R7 selects ignored
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);      // R6 wake
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);      // R11 sleep taken with irq
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);      // R11 one-cycle residency
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);      // R3 into standby
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);      // R1 reset from standby
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 50) != 0, ($urandom % 3) == 0, $urandom % 2,
                 $urandom % 2, ($urandom % 4) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule